// File: doc/BRIEF.md
# Nine-bit address-mark serial receiver

This block is the receive half of an asynchronous serial port that works with nine-bit words. On a shared multidrop line, the ninth data bit tells an address word (bit set to 1) apart from a payload word (bit cleared to 0). The receiver keeps only address words. A payload word that arrives intact is dropped with no trace. A word with a bad stop bit is always reported as an error.

The serial input passes through a synchronizer. An oversampling tick enable paces the receiver, and a bit lasts sixteen ticks. The receiver confirms a start bit at its midpoint. It then shifts nine data bits into a private shift register, least significant bit first, and samples one stop bit. Only at that stop-bit sample does it decide what to do with the word. The word can be moved into the visible data register, which sets the buffer-full flag. It can raise the combined overrun/framing error flag. Or it can be dropped.

Software reads the word with a read strobe, which empties the buffer. A separate strobe clears the error flag. The interrupt line is high while either flag is set and the interrupt enable is high.

Top module: `mp9_uart_rx`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_full`, `rx_err` and `rx_irq` are all 0.
- R2: A frame is one low start bit, then data bits D0 to D8 (least significant first), then one stop bit, each 16 ticks long and sampled at mid-bit. When D8 is 1, the stop bit is 1 and the buffer is empty, `rx_data` takes bits 8..0 = D8..D0 and `rx_full` rises. This happens in the cycle after the stop-bit sample, and no flag changes earlier in the frame.
- R3: A frame with D8 = 0 and a good stop bit changes neither `rx_data` nor any flag.
- R4: A stop bit sampled as 0 sets `rx_err` whatever D8 holds. It leaves `rx_data` and `rx_full` unchanged.
- R5: A good frame with D8 = 1 that completes while `rx_full` is still 1 (and no read strobe arrives in that cycle) sets `rx_err`. `rx_data` keeps the older word and `rx_full` stays 1.
- R6: A one-cycle `rd_strobe` clears `rx_full` in the next cycle and leaves `rx_data` unchanged. A read in the same cycle as a frame completion frees the buffer for that frame.
- R7: A one-cycle `err_clr` clears `rx_err` in the next cycle. If an error is detected in the same cycle, `rx_err` stays 1.
- R8: `rx_irq` is 1 exactly when `irq_en` is 1 and at least one of `rx_full` and `rx_err` is 1.
- R9: A start edge whose line reads high at the start bit's midpoint is dropped as a glitch. Nothing changes, and the receiver waits for the next falling edge.
- R10: While `baud_tick` is 0 the receiver does not advance, so a frame sent with no ticks has no effect.
- R11: The receiver is idle again right after the stop-bit sample. A frame whose start bit follows the stop bit directly is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data-register read, empties the buffer |
| err_clr | input | 1 | Clears the error flag |
| rx_data | output | 9 | Last accepted word, D8 in bit 8 |
| rx_full | output | 1 | Buffer-full flag |
| rx_err | output | 1 | Overrun or framing error flag |
| rx_irq | output | 1 | Interrupt request |

## Verification
The bench sends a payload word between two address words. A receiver that ignored D8 would show a spurious full flag and a changed data register. It sends two address words back to back with no read, to catch an overrun that overwrote the stored word or failed to raise the error flag. It also catches a receiver that missed a start bit placed right after a stop bit.

It sends framing errors with D8 at both 0 and 1, including one whose error clear lands in the same cycle as the error. A design that gated framing errors on D8, or let the clear win, would diverge there. A short start glitch, and a whole frame sent with the tick held low, must both leave every output untouched.

// File: rtl/mp9_rx_pkg.sv
package mp9_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/mp9_rx_sync.sv
module mp9_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mp9_rx_frame.sv
module mp9_rx_frame
    import mp9_rx_pkg::*;
#(
    parameter int WORD_W = 9,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_s,
    output logic              done,
    output logic              stop_ok,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(WORD_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] shreg;
    } frm_t;

    frm_t d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (tick) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (!line_s) begin
                        d.state = ST_START;
                        d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == MID) begin
                        d.cnt   = '0;
                        d.idx   = '0;
                        d.state = line_s ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        d.shreg = {line_s, q.shreg[WORD_W-1:1]};
                        if (q.idx == TOP) d.state = ST_STOP;
                        else              d.idx   = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        d.state = ST_IDLE;
                        done    = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, cnt: '0, idx: '0, shreg: '0};
        else        q <= d;
    end

    assign stop_ok = line_s;
    assign word    = q.shreg;
endmodule

// File: rtl/mp9_rx_flags.sv
module mp9_rx_flags #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              stop_ok,
    input  logic [WORD_W-1:0] word,
    input  logic              rd,
    input  logic              clr,
    input  logic              ie,
    output logic [WORD_W-1:0] data,
    output logic              full,
    output logic              err,
    output logic              irq
);
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              full;
        logic              err;
    } flg_t;

    flg_t d, q;

    always_comb begin
        d = q;
        if (rd)  d.full = 1'b0;
        if (clr) d.err  = 1'b0;
        if (done) begin
            if (!stop_ok) begin
                d.err = 1'b1;
            end else if (word[WORD_W-1]) begin
                if (q.full && !rd) begin
                    d.err = 1'b1;
                end else begin
                    d.full = 1'b1;
                    d.data = word;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{data: '0, full: 1'b0, err: 1'b0};
        else        q <= d;
    end

    assign data = q.data;
    assign full = q.full;
    assign err  = q.err;
    assign irq  = ie & (q.full | q.err);
endmodule

// File: rtl/mp9_uart_rx.sv
module mp9_uart_rx #(
    parameter int WORD_W      = 9,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              irq_en,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_err,
    output logic              rx_irq
);
    logic              line_s;
    logic              frame_done;
    logic              stop_ok;
    logic [WORD_W-1:0] word;

    mp9_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    mp9_rx_frame #(.WORD_W(WORD_W), .OSR(OSR)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .line_s (line_s),
        .done   (frame_done),
        .stop_ok(stop_ok),
        .word   (word)
    );

    mp9_rx_flags #(.WORD_W(WORD_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (frame_done),
        .stop_ok(stop_ok),
        .word   (word),
        .rd     (rd_strobe),
        .clr    (err_clr),
        .ie     (irq_en),
        .data   (rx_data),
        .full   (rx_full),
        .err    (rx_err),
        .irq    (rx_irq)
    );
endmodule

// File: rtl/mp9_rx_chk.sv
module mp9_rx_chk #(
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic              stop_ok,
    input logic [WORD_W-1:0] word,
    input logic              rd_strobe,
    input logic              err_clr,
    input logic              irq_en,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_full,
    input logic              rx_err,
    input logic              rx_irq
);
    AST_FULL_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && stop_ok && word[WORD_W-1] && !rx_full |=> rx_full && rx_data == $past(word)); // R2
    AST_FLAG_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) || $rose(rx_err) |-> $past(frame_done)); // R2
    AST_PAYLOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && stop_ok && !word[WORD_W-1] |=> $stable(rx_data) && !$rose(rx_full) && !$rose(rx_err)); // R3
    AST_FRAME_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !stop_ok |=> rx_err && $stable(rx_data)); // R4
    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && stop_ok && word[WORD_W-1] && rx_full && !rd_strobe |=> rx_err && rx_full && $stable(rx_data)); // R5
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !frame_done |=> !rx_full && $stable(rx_data)); // R6
    AST_CLR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !frame_done |=> !rx_err); // R7
    AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && (rx_full || rx_err) |-> rx_irq); // R8
    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full || rx_err) || !irq_en |-> !rx_irq); // R8
endmodule

bind mp9_uart_rx mp9_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .stop_ok   (stop_ok),
    .word      (word),
    .rd_strobe (rd_strobe),
    .err_clr   (err_clr),
    .irq_en    (irq_en),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .rx_err    (rx_err),
    .rx_irq    (rx_irq)
);

// File: tb/tb_mp9_uart_rx.sv
module tb_mp9_uart_rx;
    localparam int W   = 9;
    localparam int OSR = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_line = 1'b1;
    logic         baud_tick = 1'b1;
    logic         irq_en = 1'b0;
    logic         rd_strobe = 1'b0;
    logic         err_clr = 1'b0;
    logic [W-1:0] rx_data;
    logic         rx_full, rx_err, rx_irq;

    mp9_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .irq_en(irq_en), .rd_strobe(rd_strobe), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .rx_err(rx_err), .rx_irq(rx_irq)
    );

    always #5 clk = ~clk;

    int     checks = 0;
    int     fails = 0;
    int     cycles = 0;
    bit     finished = 1'b0;
    string  cur = "R1";

    // behavioural reference state
    logic [W-1:0] m_data = '0;
    bit           m_full = 0;
    bit           m_err  = 0;

    task automatic compare();
        logic [W+2:0] act, exp;
        bit           m_irq;
        m_irq = irq_en && (m_full || m_err);
        act = {rx_data, rx_full, rx_err, rx_irq};
        exp = {m_data, m_full, m_err, m_irq};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: data/full/err/irq actual %h/%b/%b/%b expected %h/%b/%b/%b",
                     cur, rx_data, rx_full, rx_err, rx_irq, m_data, m_full, m_err, m_irq);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_line = 1'b1;
            compare();
        end
    endtask

    // R2/R11: 11 bit positions of OSR clocks; tick held at 1 -> flags move after edge 170
    task automatic send_frame(input logic [W-1:0] w, input bit stop, input bit clr_same);
        logic [W+1:0] bits;
        bits = {stop, w, 1'b0};
        for (int i = 0; i < (W + 2) * OSR; i++) begin
            @(negedge clk);
            rx_line = bits[i / OSR];
            err_clr = clr_same && (i == (W + 1) * OSR + OSR / 2 + 2);
            if (i == (W + 1) * OSR + OSR / 2 + 3 && baud_tick) begin
                if (!stop) m_err = 1;
                else if (w[W-1]) begin
                    if (m_full) m_err = 1;
                    else begin m_full = 1; m_data = w; end
                end
            end
            compare();
        end
        @(negedge clk);
        err_clr = 1'b0;
        compare();
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_strobe = 1'b1; compare();
        @(negedge clk); rd_strobe = 1'b0; m_full = 0; compare();
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1; compare();
        @(negedge clk); err_clr = 1'b0; m_err = 0; compare();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
        end
    end

    initial begin
        cur = "R1";
        repeat (5) @(negedge clk);
        compare();
        rst_n = 1'b1;
        idle(8);
        irq_en = 1'b1;

        cur = "R2"; send_frame(9'h1A5, 1, 0); idle(4);
        cur = "R6"; pulse_rd(); idle(4);
        cur = "R3"; send_frame(9'h0C3, 1, 0); idle(4);
        cur = "R11"; send_frame(9'h155, 1, 0);
        cur = "R5";  send_frame(9'h1F0, 1, 0); idle(4);
        cur = "R7";  pulse_clr();
        cur = "R6";  pulse_rd(); idle(4);
        cur = "R4";  send_frame(9'h07E, 0, 0); idle(40);
        cur = "R7";  pulse_clr();
        cur = "R4";  send_frame(9'h1FF, 1, 0); idle(4);
        cur = "R4";  send_frame(9'h133, 0, 0); idle(40);
        cur = "R7";  pulse_clr();
        cur = "R7";  send_frame(9'h111, 0, 1); idle(40);
        pulse_clr();
        cur = "R9";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rx_line = 1'b0; compare();
        end
        idle(40);
        cur = "R8"; irq_en = 1'b0; idle(4);
        irq_en = 1'b1; idle(2);
        cur = "R6"; pulse_rd(); idle(4);
        cur = "R10"; baud_tick = 1'b0; send_frame(9'h1C7, 1, 0);
        idle(40); baud_tick = 1'b1; idle(40);
        cur = "R2"; send_frame(9'h101, 1, 0); idle(8);
        summary();
    end
endmodule